// File: doc/BRIEF.md
# UART-to-SPI Bridge Sequencer

This block turns a stream of bytes arriving from a UART receiver into register operations on an SPI master, and passes bytes read back from SPI slaves to a UART transmitter. The UART bit timing and the SPI serial shifting live in neighbouring blocks. This block sees the receiver as a byte plus a one-cycle valid pulse, and the transmitter as a free flag plus a one-cycle load pulse. It sees the SPI master as a small register port with an address, a write-data bus, read and write strobes, a select strobe, and a one-cycle completion pulse.

After every reset, the first received byte configures the link: slave index, clock polarity, clock phase and clock divider. These are held on dedicated configuration outputs. Every later byte is taken as a command. A write command takes the next byte and pushes it to the SPI master. A read command pushes a dummy byte so that a transfer happens. In both cases the controller fetches the byte the master shifted in once the master reports completion. On a read, that byte goes back out through the UART once the transmitter reports it is free.

Top module: `uart_spi_bridge`

## Requirements
- R1: After reset all strobes (`spi_wr`, `spi_rd`, `spi_cs`, `tx_load`) are low and the configuration outputs are zero. The first byte received after reset is stored as the configuration.
- R2: The configuration byte maps as follows: bits [7:5] give `cfg_slave`, bit 4 gives `cfg_cpol`, bit 3 gives `cfg_cpha` and bits [2:0] give `cfg_clkdiv`. Later received bytes do not change the configuration.
- R3: Command byte 0x02 followed by a data byte produces exactly one single-cycle `spi_wr` with `spi_cs` high, `spi_addr` = 1 and `spi_wdata` equal to the data byte.
- R4: Command byte 0x01 produces exactly one single-cycle `spi_wr` with `spi_cs` high, `spi_addr` = 1 and `spi_wdata` = 0x00.
- R5: The cycle after `spi_done`, the controller produces exactly one single-cycle `spi_rd` with `spi_cs` high and `spi_addr` = 2, capturing `spi_rdata` in that cycle.
- R6: In a read flow, the captured byte is handed to the transmitter with exactly one single-cycle `tx_load`, on `tx_data`. This happens only in a cycle where `tx_ready` is high, and the controller waits as long as `tx_ready` stays low.
- R7: A write flow never asserts `tx_load`.
- R8: Any command byte other than 0x01 or 0x02 is discarded with no SPI or UART activity. The next byte is again taken as a command.
- R9: Bytes received while an SPI transfer or a transmit hand-off is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_data | input | 8 | Byte from UART receiver |
| rx_valid | input | 1 | One-cycle pulse: `rx_data` holds a new byte |
| tx_ready | input | 1 | UART transmitter is free |
| tx_data | output | 8 | Byte for UART transmitter |
| tx_load | output | 1 | One-cycle pulse: transmitter takes `tx_data` |
| spi_addr | output | 2 | SPI master register address (1 = transmit, 2 = receive) |
| spi_wdata | output | 8 | Write data to SPI master |
| spi_wr | output | 1 | Write strobe |
| spi_rd | output | 1 | Read strobe |
| spi_cs | output | 1 | Register select strobe |
| spi_rdata | input | 8 | Read data from SPI master |
| spi_done | input | 1 | One-cycle pulse: SPI transfer finished |
| cfg_slave | output | 3 | Slave index |
| cfg_cpol | output | 1 | Clock polarity |
| cfg_cpha | output | 1 | Clock phase |
| cfg_clkdiv | output | 3 | Clock divider select |

## Verification
On every cycle, the assertions check the local properties of the strobes. Write and read strobes last one cycle and carry the transmit and receive addresses respectively. A transmitter load happens only while the transmitter is free and never twice in a row. The configuration holds still once set. Only the bench scenarios can show the sequencing: which byte lands in the configuration, and that a write carries the second byte while a read carries a zero dummy. They also show that the byte read back reaches the UART only on a read, and that unknown commands and bytes arriving mid-transfer leave no trace.

// File: rtl/uart_spi_bridge.sv
module uart_spi_bridge #(
  parameter int DW = 8,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_valid,
  input  logic          tx_ready,
  output logic [DW-1:0] tx_data,
  output logic          tx_load,
  output logic [AW-1:0] spi_addr,
  output logic [DW-1:0] spi_wdata,
  output logic          spi_wr,
  output logic          spi_rd,
  output logic          spi_cs,
  input  logic [DW-1:0] spi_rdata,
  input  logic          spi_done,
  output logic [2:0]    cfg_slave,
  output logic          cfg_cpol,
  output logic          cfg_cpha,
  output logic [2:0]    cfg_clkdiv
);
  localparam logic [DW-1:0] CMD_RD = DW'(8'h01);
  localparam logic [DW-1:0] CMD_WR = DW'(8'h02);
  localparam logic [AW-1:0] A_TX   = AW'(1);
  localparam logic [AW-1:0] A_RX   = AW'(2);

  typedef enum logic [2:0] {
    S_CFG, S_CMD, S_DATA, S_PUSH, S_BUSY, S_PULL, S_HOLD
  } state_t;

  state_t        st;
  logic [7:0]    ctrl_q;
  logic [DW-1:0] txr_q, rxr_q;
  logic          rd_flow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_CFG;
      ctrl_q  <= '0;
      txr_q   <= '0;
      rxr_q   <= '0;
      rd_flow <= 1'b0;
    end else begin
      case (st)
        S_CFG: if (rx_valid) begin
          ctrl_q <= rx_data[7:0];
          st     <= S_CMD;
        end
        S_CMD: if (rx_valid) begin
          if (rx_data == CMD_WR) begin
            rd_flow <= 1'b0;
            st      <= S_DATA;
          end else if (rx_data == CMD_RD) begin
            rd_flow <= 1'b1;
            txr_q   <= '0;
            st      <= S_PUSH;
          end
        end
        S_DATA: if (rx_valid) begin
          txr_q <= rx_data;
          st    <= S_PUSH;
        end
        S_PUSH: st <= S_BUSY;
        S_BUSY: if (spi_done) st <= S_PULL;
        S_PULL: begin
          rxr_q <= spi_rdata;
          st    <= rd_flow ? S_HOLD : S_CMD;
        end
        S_HOLD: if (tx_ready) st <= S_CMD;
        default: st <= S_CFG;
      endcase
    end
  end

  assign spi_wr     = (st == S_PUSH);
  assign spi_rd     = (st == S_PULL);
  assign spi_cs     = spi_wr | spi_rd;
  assign spi_addr   = spi_rd ? A_RX : A_TX;
  assign spi_wdata  = txr_q;
  assign tx_load    = (st == S_HOLD) && tx_ready;
  assign tx_data    = rxr_q;
  assign cfg_slave  = ctrl_q[7:5];
  assign cfg_cpol   = ctrl_q[4];
  assign cfg_cpha   = ctrl_q[3];
  assign cfg_clkdiv = ctrl_q[2:0];
endmodule

// File: rtl/uart_spi_bridge_chk.sv
module uart_spi_bridge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_valid,
  input logic       tx_ready,
  input logic       tx_load,
  input logic [1:0] spi_addr,
  input logic       spi_wr,
  input logic       spi_rd,
  input logic       spi_cs,
  input logic [2:0] cfg_slave,
  input logic       cfg_cpol,
  input logic       cfg_cpha,
  input logic [2:0] cfg_clkdiv
);
  logic configured;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) configured <= 1'b0;
    else if (rx_valid) configured <= 1'b1;

  assert_wr_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    spi_wr |=> !spi_wr);
  assert_wr_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    spi_wr |-> (spi_addr == 2'd1) && spi_cs && !spi_rd);
  assert_rd_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    spi_rd |=> !spi_rd);
  assert_rd_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    spi_rd |-> (spi_addr == 2'd2) && spi_cs);
  assert_load_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> tx_ready);
  assert_load_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> !tx_load);
  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (configured && $past(configured)) |->
      ($stable(cfg_slave) && $stable(cfg_cpol) && $stable(cfg_cpha) && $stable(cfg_clkdiv)));
endmodule

bind uart_spi_bridge uart_spi_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .tx_ready(tx_ready),
  .tx_load(tx_load), .spi_addr(spi_addr), .spi_wr(spi_wr), .spi_rd(spi_rd),
  .spi_cs(spi_cs), .cfg_slave(cfg_slave), .cfg_cpol(cfg_cpol),
  .cfg_cpha(cfg_cpha), .cfg_clkdiv(cfg_clkdiv)
);

// File: tb/uart_spi_bridge_test.sv
`timescale 1ns/1ps
module uart_spi_bridge_test;
  logic       clk = 0, rst_n = 0;
  logic [7:0] rx_data = 0, spi_rdata = 8'h3C;
  logic       rx_valid = 0, tx_ready = 0, spi_done = 0;
  logic [7:0] tx_data, spi_wdata;
  logic       tx_load, spi_wr, spi_rd, spi_cs, cfg_cpol, cfg_cpha;
  logic [1:0] spi_addr;
  logic [2:0] cfg_slave, cfg_clkdiv;

  int checks = 0, failures = 0;
  int n_wr = 0, n_rd = 0, n_tx = 0, n_cs_bad = 0;
  logic [7:0] last_wdata = 0, last_tx = 0;
  logic [1:0] last_wr_addr = 0, last_rd_addr = 0;

  always #2 clk = ~clk;

  uart_spi_bridge uut (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_load(tx_load),
    .spi_addr(spi_addr), .spi_wdata(spi_wdata), .spi_wr(spi_wr),
    .spi_rd(spi_rd), .spi_cs(spi_cs), .spi_rdata(spi_rdata),
    .spi_done(spi_done), .cfg_slave(cfg_slave), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_clkdiv(cfg_clkdiv)
  );

  always @(negedge clk) begin
    if (spi_wr) begin n_wr++; last_wdata = spi_wdata; last_wr_addr = spi_addr; end
    if (spi_rd) begin n_rd++; last_rd_addr = spi_addr; end
    if ((spi_wr || spi_rd) && !spi_cs) n_cs_bad++;
    if (tx_load) begin n_tx++; last_tx = tx_data; end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (spi_wr) begin
        repeat (4) @(negedge clk);
        spi_done = 1;
        @(negedge clk);
        spi_done = 0;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_counts();
    n_wr = 0; n_rd = 0; n_tx = 0; n_cs_bad = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_data = b; rx_valid = 1;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic t_reset_cfg();
    do_reset();
    check("R1 wr", spi_wr, 0); check("R1 rd", spi_rd, 0);
    check("R1 cs", spi_cs, 0); check("R1 load", tx_load, 0);
    check("R1 cfg", {cfg_slave, cfg_cpol, cfg_cpha, cfg_clkdiv}, 0);
    send_byte(8'hB5);
    @(negedge clk);
    check("R2 slave", cfg_slave, 5); check("R2 cpol", cfg_cpol, 1);
    check("R2 cpha", cfg_cpha, 0);   check("R2 div", cfg_clkdiv, 5);
  endtask

  task automatic t_write();
    clear_counts(); tx_ready = 1; spi_rdata = 8'h66;
    send_byte(8'h02); send_byte(8'hA7);
    repeat (14) @(negedge clk);
    check("R3 wr count", n_wr, 1); check("R3 wr addr", last_wr_addr, 1);
    check("R3 wdata", last_wdata, 8'hA7); check("R3 cs", n_cs_bad, 0);
    check("R5 rd count", n_rd, 1); check("R5 rd addr", last_rd_addr, 2);
    check("R7 no load", n_tx, 0);
    check("R2 cfg kept", {cfg_slave, cfg_cpol, cfg_cpha, cfg_clkdiv}, 8'hB5);
  endtask

  task automatic t_read();
    clear_counts(); tx_ready = 0; spi_rdata = 8'h3C;
    send_byte(8'h01);
    repeat (20) @(negedge clk);
    check("R4 wr count", n_wr, 1); check("R4 dummy", last_wdata, 0);
    check("R4 wr addr", last_wr_addr, 1);
    check("R5 rd count", n_rd, 1);
    check("R6 waits", n_tx, 0);
    tx_ready = 1;
    repeat (4) @(negedge clk);
    check("R6 load count", n_tx, 1); check("R6 data", last_tx, 8'h3C);
  endtask

  task automatic t_unknown();
    clear_counts(); tx_ready = 1;
    send_byte(8'h55); send_byte(8'h00); send_byte(8'h03);
    repeat (10) @(negedge clk);
    check("R8 no wr", n_wr, 0); check("R8 no load", n_tx, 0);
    send_byte(8'h02); send_byte(8'h19);
    repeat (14) @(negedge clk);
    check("R8 cmd after", n_wr, 1); check("R8 data", last_wdata, 8'h19);
  endtask

  task automatic t_busy_ignore();
    clear_counts(); tx_ready = 1; spi_rdata = 8'h77;
    send_byte(8'h02); send_byte(8'h4E);
    send_byte(8'h01);
    send_byte(8'h02);
    repeat (20) @(negedge clk);
    check("R9 one wr", n_wr, 1); check("R9 data", last_wdata, 8'h4E);
    check("R9 no load", n_tx, 0);
    check("R2 cfg kept", {cfg_slave, cfg_cpol, cfg_cpha, cfg_clkdiv}, 8'hB5);
  endtask

  task automatic t_reconfig();
    do_reset();
    check("R1 cfg cleared", {cfg_slave, cfg_cpol, cfg_cpha, cfg_clkdiv}, 0);
    clear_counts();
    send_byte(8'h02);
    @(negedge clk);
    check("R1 first is cfg", {cfg_slave, cfg_cpol, cfg_cpha, cfg_clkdiv}, 8'h02);
    send_byte(8'h4B);
    repeat (4) @(negedge clk);
    check("R1 no wr", n_wr, 0);
    check("R2 cfg kept", {cfg_slave, cfg_cpol, cfg_cpha, cfg_clkdiv}, 8'h02);
  endtask

  initial begin
    t_reset_cfg();
    t_write();
    t_read();
    t_unknown();
    t_busy_ignore();
    t_reconfig();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule